// File: doc/BRIEF.md
# Gather Partial-Sum Injection Unit

This unit sits on one output port of a mesh router, between the upstream link and the downstream link. A local processing element hands it one partial sum at a time. The unit then watches the flits passing through. When a passing gather packet still has a free payload slot, the unit writes the waiting sum into the first free slot and lowers the packet's free-slot count. Many results can then reach one collecting node inside a single packet. Unicast, multicast and reserved traffic passes through untouched. If no usable gather packet arrives within a programmable number of cycles, the unit builds a fresh gather packet around its own sum. It sends that packet in a cycle when no transit flit is offered, so transit traffic is never delayed.

Each packet is a single flit that holds both the header and the payload. From the most significant end, the flit holds a 2-bit kind field, a 4-bit free-slot count, the destination field, and SLOTS payload slots of SUM_W bits each. Slot 0 is at the least significant end. A gather packet fills its slots from slot 0 upward, so the next free slot is always slot SLOTS minus the free-slot count. Every outgoing flit passes through one output register.

The holding logic is a three-state machine. The states are HOLD_IDLE (nothing pending, PE side ready), HOLD_WAIT (sum held, timeout counter running) and HOLD_EXPIRED (sum held, threshold reached, injection allowed). The machine moves from HOLD_IDLE to HOLD_WAIT when a sum is accepted. It moves from HOLD_WAIT back to HOLD_IDLE when the sum is absorbed into a passing packet. It moves from HOLD_WAIT to HOLD_EXPIRED when the counter has reached the threshold. It moves from HOLD_EXPIRED to HOLD_IDLE when the sum is absorbed or injected.

Top module: `gather_inject_unit`

## Requirements
- R1: After reset, out_valid is 0, pe_ready is 1 and in_ready is 1.
- R2: A flit whose kind field (bits FLIT_W-1:FLIT_W-2) is 00 (unicast), 01 (multicast) or 11 (reserved) appears bit-identical on out_flit, with out_valid asserted, one cycle after it is accepted.
- R3: A gather flit (kind 10) leaves unchanged when no sum is pending, or when its free-slot count (bits FLIT_W-3:FLIT_W-6) is 0 or greater than SLOTS. In both cases a pending sum stays pending.
- R4: When a sum is pending and a gather flit with free-slot count k (1 <= k <= SLOTS) is accepted, the output flit one cycle later carries the sum in slot SLOTS-k (bits (SLOTS-k)*SUM_W and up) and a free-slot count of k-1. All other fields are unchanged, and pe_ready returns to 1.
- R5: Only one sum is held at a time. pe_ready is 0 from the cycle after a sum is accepted until that sum has been absorbed or injected.
- R6: With no transit traffic, a sum accepted on clock edge E is injected so that out_valid rises right after edge E+T+2, where T is cfg_timeout. The injected flit has kind 10, free-slot count SLOTS-1, destination cfg_dest, the sum in slot 0, and all other slots zero.
- R7: No injection is made in a cycle where in_valid is 1. An expired sum waits behind a continuous transit stream and is injected after the stream ends.
- R8: While out_valid is 1 and out_ready is 0, out_flit holds steady and no input flit is accepted. A gather flit that waits during the stall is modified only when it is finally accepted.
- R9: A pending sum whose timeout has already expired is still absorbed into a usable gather flit, and no separate packet is then injected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_timeout | input | TMO_W (16) | Cycles to wait for a usable gather packet |
| cfg_dest | input | DEST_W (6) | Destination field for injected gather packets |
| pe_valid | input | 1 | Processing element offers a partial sum |
| pe_ready | output | 1 | Unit can take a partial sum |
| pe_sum | input | SUM_W (16) | Partial sum value |
| in_valid | input | 1 | Upstream flit valid |
| in_ready | output | 1 | Unit accepts the upstream flit |
| in_flit | input | FLIT_W (140) | Upstream flit |
| out_valid | output | 1 | Downstream flit valid |
| out_ready | input | 1 | Downstream accepts the flit |
| out_flit | output | FLIT_W (140) | Downstream flit |

## Verification
The assertions check the per-cycle link rules on every cycle. These are the unchanged pass-through of non-gather and full gather flits, the one-step decrement of the free-slot count when a sum is absorbed, the frozen output during a stall, and the single-sum rule on the PE side. Other behaviours depend on a sequence of events, so only the bench scenarios can show them. These are the exact slot that receives a sum, the exact cycle at which a timeout injection appears, the order of an injected packet behind a continuous transit stream, and the absence of any injection once an expired sum has been absorbed.

// File: rtl/gpi_pkg.sv
`timescale 1ns/1ps
package gpi_pkg;
    localparam int KIND_W  = 2;
    localparam int AVAIL_W = 4;

    typedef enum logic [KIND_W-1:0] {
        KIND_UNICAST   = 2'b00,
        KIND_MULTICAST = 2'b01,
        KIND_GATHER    = 2'b10,
        KIND_RESERVED  = 2'b11
    } pkt_kind_e;

    typedef enum logic [1:0] {
        HOLD_IDLE    = 2'b00,
        HOLD_WAIT    = 2'b01,
        HOLD_EXPIRED = 2'b10
    } hold_state_e;
endpackage

// File: rtl/gpi_hdr_parse.sv
`timescale 1ns/1ps
module gpi_hdr_parse
    import gpi_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input  logic [KIND_W+AVAIL_W-1:0] hdr,
    output logic                      is_gather,
    output logic                      has_room
);
    pkt_kind_e            kind;
    logic [AVAIL_W-1:0]   avail;

    always_comb begin
        kind      = pkt_kind_e'(hdr[KIND_W+AVAIL_W-1 -: KIND_W]);
        avail     = hdr[AVAIL_W-1:0];
        is_gather = (kind == KIND_GATHER);
        // a slot is usable only when the count is nonzero and plausible
        has_room  = is_gather && (avail != '0) &&
                    (avail <= AVAIL_W'(SLOTS));
    end
endmodule

// File: rtl/gpi_slot_insert.sv
`timescale 1ns/1ps
module gpi_slot_insert
    import gpi_pkg::*;
#(
    parameter int SUM_W  = 16,
    parameter int SLOTS  = 8,
    parameter int DEST_W = 6,
    localparam int PAY_W  = SUM_W * SLOTS,
    localparam int FLIT_W = KIND_W + AVAIL_W + DEST_W + PAY_W
) (
    input  logic [FLIT_W-1:0] flit_in,
    input  logic [SUM_W-1:0]  sum,
    input  logic              en,
    output logic [FLIT_W-1:0] flit_out
);
    logic [AVAIL_W-1:0] avail_in;
    logic [AVAIL_W-1:0] avail_out;
    logic [PAY_W-1:0]   pay_out;

    assign avail_in  = flit_in[PAY_W+DEST_W +: AVAIL_W];
    assign avail_out = en ? (avail_in - AVAIL_W'(1)) : avail_in;

    // slot g is the next free one exactly when the free count is SLOTS-g
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic hit;
        assign hit = en && (avail_in == AVAIL_W'(SLOTS - g));
        assign pay_out[g*SUM_W +: SUM_W] =
            hit ? sum : flit_in[g*SUM_W +: SUM_W];
    end

    assign flit_out = {flit_in[FLIT_W-1 -: KIND_W], avail_out,
                       flit_in[PAY_W +: DEST_W], pay_out};
endmodule

// File: rtl/gpi_hold_fsm.sv
`timescale 1ns/1ps
module gpi_hold_fsm
    import gpi_pkg::*;
#(
    parameter int SUM_W = 16,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMO_W-1:0] thr,
    input  logic             pe_valid,
    input  logic [SUM_W-1:0] pe_sum,
    input  logic             absorb,
    input  logic             inject,
    output logic             pe_ready,
    output logic             pending,
    output logic             expired,
    output logic [SUM_W-1:0] held_sum
);
    hold_state_e      state, state_nx;
    logic [TMO_W-1:0] cnt;
    logic             take;

    assign take = (state == HOLD_IDLE) && pe_valid;

    always_comb begin
        state_nx = state;
        unique case (state)
            HOLD_IDLE:    if (pe_valid) state_nx = HOLD_WAIT;
            HOLD_WAIT: begin
                if (absorb)          state_nx = HOLD_IDLE;
                else if (cnt >= thr) state_nx = HOLD_EXPIRED;
            end
            HOLD_EXPIRED: if (absorb || inject) state_nx = HOLD_IDLE;
            default:      state_nx = HOLD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= HOLD_IDLE;
            cnt      <= '0;
            held_sum <= '0;
        end else begin
            state <= state_nx;
            if (take) begin
                cnt      <= '0;
                held_sum <= pe_sum;
            end else if (state == HOLD_WAIT && !absorb && cnt < thr) begin
                cnt <= cnt + TMO_W'(1);
            end
        end
    end

    always_comb begin
        pe_ready = 1'b0;
        pending  = 1'b0;
        expired  = 1'b0;
        unique case (state)
            HOLD_IDLE:    pe_ready = 1'b1;
            HOLD_WAIT:    pending  = 1'b1;
            HOLD_EXPIRED: begin
                pending = 1'b1;
                expired = 1'b1;
            end
            default:      pe_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpi_out_stage.sv
`timescale 1ns/1ps
module gpi_out_stage #(
    parameter int FLIT_W = 140
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [FLIT_W-1:0] load_flit,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [FLIT_W-1:0] out_flit,
    output logic              can_load
);
    assign can_load = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_flit  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_flit  <= load_flit;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/gather_inject_unit.sv
`timescale 1ns/1ps
module gather_inject_unit
    import gpi_pkg::*;
#(
    parameter int SUM_W  = 16,
    parameter int SLOTS  = 8,
    parameter int DEST_W = 6,
    parameter int TMO_W  = 16,
    localparam int PAY_W  = SUM_W * SLOTS,
    localparam int FLIT_W = KIND_W + AVAIL_W + DEST_W + PAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMO_W-1:0]  cfg_timeout,
    input  logic [DEST_W-1:0] cfg_dest,
    input  logic              pe_valid,
    output logic              pe_ready,
    input  logic [SUM_W-1:0]  pe_sum,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [FLIT_W-1:0] in_flit,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [FLIT_W-1:0] out_flit
);
    logic              is_gather, has_room;
    logic              pending, expired;
    logic [SUM_W-1:0]  held_sum;
    logic              can_load, in_fire, absorb, inject, load;
    logic [FLIT_W-1:0] mod_flit, inj_flit, load_flit;

    gpi_hdr_parse #(.SLOTS(SLOTS)) u_parse (
        .hdr       (in_flit[FLIT_W-1 -: KIND_W+AVAIL_W]),
        .is_gather (is_gather),
        .has_room  (has_room)
    );

    assign in_ready = can_load;
    assign in_fire  = in_valid && in_ready;
    assign absorb   = in_fire && is_gather && has_room && pending;
    // transit traffic has priority over a self-started packet
    assign inject   = expired && !in_valid && can_load;
    assign load     = in_fire || inject;

    gpi_slot_insert #(.SUM_W(SUM_W), .SLOTS(SLOTS), .DEST_W(DEST_W)) u_ins (
        .flit_in  (in_flit),
        .sum      (held_sum),
        .en       (absorb),
        .flit_out (mod_flit)
    );

    assign inj_flit  = {KIND_GATHER, AVAIL_W'(SLOTS - 1), cfg_dest,
                        {(PAY_W-SUM_W){1'b0}}, held_sum};
    assign load_flit = in_fire ? mod_flit : inj_flit;

    gpi_hold_fsm #(.SUM_W(SUM_W), .TMO_W(TMO_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .thr      (cfg_timeout),
        .pe_valid (pe_valid),
        .pe_sum   (pe_sum),
        .absorb   (absorb),
        .inject   (inject),
        .pe_ready (pe_ready),
        .pending  (pending),
        .expired  (expired),
        .held_sum (held_sum)
    );

    gpi_out_stage #(.FLIT_W(FLIT_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_flit (load_flit),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_flit  (out_flit),
        .can_load  (can_load)
    );
endmodule

// File: rtl/gather_inject_unit_chk.sv
`timescale 1ns/1ps
module gather_inject_unit_chk
    import gpi_pkg::*;
#(
    parameter int SUM_W  = 16,
    parameter int SLOTS  = 8,
    parameter int DEST_W = 6,
    localparam int FLIT_W = KIND_W + AVAIL_W + DEST_W + SUM_W * SLOTS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pe_valid,
    input logic              pe_ready,
    input logic              in_valid,
    input logic              in_ready,
    input logic [FLIT_W-1:0] in_flit,
    input logic              out_valid,
    input logic              out_ready,
    input logic [FLIT_W-1:0] out_flit
);
    logic [KIND_W-1:0]  in_kind;
    logic [AVAIL_W-1:0] in_avail, out_avail;
    logic               in_fire;

    assign in_kind   = in_flit[FLIT_W-1 -: KIND_W];
    assign in_avail  = in_flit[FLIT_W-KIND_W-1 -: AVAIL_W];
    assign out_avail = out_flit[FLIT_W-KIND_W-1 -: AVAIL_W];
    assign in_fire   = in_valid && in_ready;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && pe_ready));

    // R2
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && in_kind != KIND_GATHER) |=>
            (out_valid && out_flit == $past(in_flit)));

    // R3
    full_gather_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && in_kind == KIND_GATHER && in_avail == '0) |=>
            (out_valid && out_flit == $past(in_flit)));

    // R4
    slot_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && in_kind == KIND_GATHER && !pe_ready &&
         in_avail != '0 && in_avail <= AVAIL_W'(SLOTS)) |=>
            (out_avail == $past(in_avail) - AVAIL_W'(1)));

    // R5
    one_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_valid && pe_ready) |=> !pe_ready);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_flit)));
endmodule

bind gather_inject_unit gather_inject_unit_chk #(
    .SUM_W(SUM_W), .SLOTS(SLOTS), .DEST_W(DEST_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pe_valid  (pe_valid),
    .pe_ready  (pe_ready),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_flit   (in_flit),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_flit  (out_flit)
);

// File: tb/gather_inject_unit_bench.sv
`timescale 1ns/1ps
module gather_inject_unit_bench;
    localparam int FW = 140;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   cfg_timeout = 16'd1000;
    logic [5:0]    cfg_dest = 6'h2A;
    logic          pe_valid = 1'b0;
    logic          pe_ready;
    logic [15:0]   pe_sum = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [FW-1:0] in_flit = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [FW-1:0] out_flit;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    int acc_cyc = 0;
    logic [FW-1:0] exp_q[$];
    string         tag_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gather_inject_unit u_gather_inject_unit (
        .clk(clk), .rst_n(rst_n), .cfg_timeout(cfg_timeout),
        .cfg_dest(cfg_dest), .pe_valid(pe_valid), .pe_ready(pe_ready),
        .pe_sum(pe_sum), .in_valid(in_valid), .in_ready(in_ready),
        .in_flit(in_flit), .out_valid(out_valid), .out_ready(out_ready),
        .out_flit(out_flit)
    );

    function automatic [FW-1:0] mkf(input [1:0] k, input [3:0] a,
                                    input [5:0] d, input [127:0] p);
        return {k, a, d, p};
    endfunction

    function automatic [127:0] put(input [127:0] p, input int i,
                                   input [15:0] v);
        p[i*16 +: 16] = v;
        return p;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input [FW-1:0] act, input [FW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected output", out_flit, '0);
            end else begin
                logic [FW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(out_flit == e, t, out_flit, e);
            end
        end
    end

    task automatic expect_flit(input [FW-1:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    // called at posedge+1; returns at posedge+1 after the handshake edge
    task automatic send_flit(input [FW-1:0] f, input [FW-1:0] e,
                             input string t, input bit last);
        expect_flit(e, t);
        in_valid = 1'b1;
        in_flit  = f;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        if (last) in_valid = 1'b0;
    endtask

    task automatic pe_send(input [15:0] s);
        pe_valid = 1'b1;
        pe_sum   = s;
        do @(negedge clk); while (!pe_ready);
        @(posedge clk); #1;
        pe_valid = 1'b0;
        acc_cyc  = cyc;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic [FW-1:0] injected(input [15:0] s);
        return mkf(2'b10, 4'd7, 6'h2A, put('0, 0, s));
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "watchdog", '0, '0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [127:0] p;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!out_valid && pe_ready && in_ready, "R1 reset state",
            {out_valid, pe_ready, in_ready}, 3'b011);
        @(posedge clk); #1;

        // R2: non-gather kinds pass unchanged, back to back
        send_flit(mkf(2'b00, 4'd3, 6'h01, 128'h1234), mkf(2'b00, 4'd3, 6'h01, 128'h1234), "R2 unicast", 1'b0);
        send_flit(mkf(2'b01, 4'd0, 6'h3F, {8{16'hA5A5}}), mkf(2'b01, 4'd0, 6'h3F, {8{16'hA5A5}}), "R2 multicast", 1'b0);
        send_flit(mkf(2'b11, 4'd9, 6'h10, 128'hDEAD_0000_BEEF), mkf(2'b11, 4'd9, 6'h10, 128'hDEAD_0000_BEEF), "R2 reserved", 1'b1);

        // R3: gather with nothing pending passes unchanged
        p = put(put('0, 0, 16'h0011), 1, 16'h0022);
        send_flit(mkf(2'b10, 4'd6, 6'h05, p), mkf(2'b10, 4'd6, 6'h05, p), "R3 gather no pending", 1'b1);
        idle(2);

        // R4/R5: absorb into slot 5 of a packet with 3 free slots
        pe_send(16'hABCD);
        @(negedge clk);
        // R5
        chk(!pe_ready, "R5 ready low while held", {139'd0, pe_ready}, '0);
        @(posedge clk); #1;
        p = '0;
        for (int i = 0; i < 5; i++) p = put(p, i, 16'h1000 + 16'(i));
        send_flit(mkf(2'b10, 4'd3, 6'h07, p), mkf(2'b10, 4'd2, 6'h07, put(p, 5, 16'hABCD)), "R4 slot 5", 1'b1);
        @(negedge clk);
        chk(pe_ready, "R4 ready after absorb", {139'd0, pe_ready}, 1);
        @(posedge clk); #1;

        // R4: empty packet (slot 0) and last free slot (slot 7)
        pe_send(16'h0102);
        send_flit(mkf(2'b10, 4'd8, 6'h09, '0), mkf(2'b10, 4'd7, 6'h09, put('0, 0, 16'h0102)), "R4 slot 0", 1'b1);
        pe_send(16'h7777);
        p = {16'h0, {7{16'h3333}}};
        send_flit(mkf(2'b10, 4'd1, 6'h09, p), mkf(2'b10, 4'd0, 6'h09, put(p, 7, 16'h7777)), "R4 slot 7", 1'b1);

        // R3: full and implausible counts pass unchanged, sum stays held
        pe_send(16'h5A5A);
        p = {8{16'h4444}};
        send_flit(mkf(2'b10, 4'd0, 6'h0C, p), mkf(2'b10, 4'd0, 6'h0C, p), "R3 full gather", 1'b0);
        send_flit(mkf(2'b10, 4'd9, 6'h0C, p), mkf(2'b10, 4'd9, 6'h0C, p), "R3 count above slots", 1'b1);
        @(negedge clk);
        chk(!pe_ready, "R3 sum still held", {139'd0, pe_ready}, '0);
        @(posedge clk); #1;
        p = {32'h0, {6{16'h6666}}};
        send_flit(mkf(2'b10, 4'd2, 6'h0C, p), mkf(2'b10, 4'd1, 6'h0C, put(p, 6, 16'h5A5A)), "R3 later absorb slot 6", 1'b1);
        idle(3);

        // R6: timeout injection timing and format
        cfg_timeout = 16'd5;
        expect_flit(injected(16'hBEEF), "R6 injected format");
        pe_send(16'hBEEF);
        do @(negedge clk); while (!out_valid);
        chk(cyc - acc_cyc == 7, "R6 injection cycle", FW'(cyc - acc_cyc), FW'(7));
        @(posedge clk); #1;
        idle(2);

        // R7: continuous transit stream delays an expired injection
        cfg_timeout = 16'd1;
        pe_send(16'hC0DE);
        for (int i = 0; i < 6; i++)
            send_flit(mkf(2'b00, 4'd0, 6'(i), 128'(i)), mkf(2'b00, 4'd0, 6'(i), 128'(i)), "R7 transit first", i == 5);
        expect_flit(injected(16'hC0DE), "R7 injected after stream");
        @(negedge clk);
        chk(!pe_ready, "R7 no injection during stream", {139'd0, pe_ready}, '0);
        idle(4);

        // R9: expired sum absorbed, no separate injection
        pe_send(16'hD00D);
        for (int i = 0; i < 4; i++)
            send_flit(mkf(2'b01, 4'd0, 6'h11, 128'(i + 40)), mkf(2'b01, 4'd0, 6'h11, 128'(i + 40)), "R9 transit", 1'b0);
        p = {64'h0, {4{16'h2222}}};
        send_flit(mkf(2'b10, 4'd6, 6'h12, p), mkf(2'b10, 4'd5, 6'h12, put(p, 2, 16'hD00D)), "R9 absorb after expiry", 1'b1);
        idle(8);
        chk(exp_q.size() == 0 && pe_ready, "R9 nothing injected", FW'(exp_q.size()), '0);

        // R8: stall holds output, blocks input, defers slot write
        cfg_timeout = 16'd1000;
        out_ready = 1'b0;
        send_flit(mkf(2'b00, 4'd1, 6'h21, 128'hCAFE), mkf(2'b00, 4'd1, 6'h21, 128'hCAFE), "R8 stalled flit", 1'b1);
        pe_send(16'h9999);
        p = {16'h0, {7{16'h0}}};
        fork
            send_flit(mkf(2'b10, 4'd8, 6'h22, p), mkf(2'b10, 4'd7, 6'h22, put(p, 0, 16'h9999)), "R8 deferred absorb", 1'b1);
            begin
                for (int i = 0; i < 3; i++) begin
                    @(negedge clk);
                    chk(out_valid && !in_ready && out_flit == mkf(2'b00, 4'd1, 6'h21, 128'hCAFE),
                        "R8 output held", out_flit, mkf(2'b00, 4'd1, 6'h21, 128'hCAFE));
                end
                chk(!pe_ready, "R8 sum held during stall", {139'd0, pe_ready}, '0);
                @(posedge clk); #1;
                out_ready = 1'b1;
            end
        join
        idle(6);
        chk(exp_q.size() == 0, "R8 all outputs seen", FW'(exp_q.size()), '0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule